// File: doc/BRIEF.md
# Dual-Speed Clock Enable Generator

This block produces one-clock-wide enable strobes from the oscillator clock. One strobe paces the machine cycle of a small 8-bit controller core. Six more pace its peripherals: three timers, the serial port, the counter array and the watchdog. No clock is divided or muxed. Every consumer runs on the oscillator clock and advances only when its strobe is high.

A byte-wide speed register on a simple register bus selects the pacing. At standard speed, every strobe repeats once per 12 oscillator periods. When the global double-speed bit is set, the core strobe repeats every 6 periods. Each peripheral then follows its own select bit: it either joins the fast rate or stays at the standard rate.

All strobes come from one shared 12-state phase counter, so they stay phase-aligned. A lane that changes speed picks up its new setting only at the start of a 12-period frame. No strobe comes early and no period is cut short.

Top module: `dual_speed_cken`

## Requirements
- R1: After reset, the speed register reads 0x00 and every strobe (core and all six peripherals) repeats once per 12 clock periods.
- R2: The speed register sits at address 0x8F. Bit 0 is the global double-speed bit. Bits 1 to 6 are the standard-speed selects of per_stb[0] to per_stb[5], in the order timer 0, timer 1, timer 2, serial port, counter array, watchdog. A write with reg_we high to any other address leaves the register unchanged.
- R3: Register reads have one clock of latency: reg_rdata after a rising edge shows the register if reg_addr was 0x8F at that edge, and 0x00 for any other address.
- R4: Bit 7 of the register always reads 0, and writing it has no effect.
- R5: While bit 0 is 0, every peripheral strobe repeats once per 12 clock periods, whatever bits 1 to 6 hold.
- R6: While bit 0 is 1, core_stb repeats every 6 clock periods. A peripheral whose select bit is 0 repeats every 6 periods, and one whose select bit is 1 repeats every 12 periods.
- R7: Each strobe is high for exactly one clock. Every strobe at the 12-period rate coincides with a core_stb pulse.
- R8: A speed change takes effect only at the next 12-period frame boundary. Before and after the switch, every interval between strobes of a lane is 6 or 12 periods. The interval in progress when the write lands keeps its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| core_stb | output | 1 | Core machine-cycle enable strobe |
| per_stb | output | 6 | Peripheral enable strobes (timer 0, timer 1, timer 2, serial, counter array, watchdog) |

## Verification
Some checks hold on every cycle, and the assertions cover these. The phase counter stays in range. A strobe only fires on a phase tick. A lane's latched speed only changes at the frame start. A peripheral is never fast while the core is slow. The reserved bit reads zero. A write to a foreign address leaves the register stable.

The actual strobe periods can only be shown by the bench's interval counting. So can the bit-to-peripheral mapping, the alignment of slow strobes with the core strobe, and the interval sequence across a mid-frame speed switch. The bench sweeps all 128 settings of the seven live bits to cover these.

// File: rtl/cken_pkg.sv
package cken_pkg;
   // Lane numbering of the peripheral strobe vector; the register bit of lane n is n+1
   typedef enum logic [2:0] {
      LANE_TMR0  = 3'd0,
      LANE_TMR1  = 3'd1,
      LANE_TMR2  = 3'd2,
      LANE_SER   = 3'd3,
      LANE_CARR  = 3'd4,
      LANE_WDOG  = 3'd5
   } per_lane_e;

   localparam int unsigned DEF_SLOW_DIV = 12;
   localparam int unsigned DEF_FAST_DIV = 6;
   localparam int unsigned DEF_NUM_PER  = 6;

   function automatic logic [7:0] live_mask(input int unsigned nper);
      logic [7:0] m;
      m = '0;
      for (int unsigned i = 0; i < 8; i++) begin
         if (i <= nper) m[i] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/cken_phase_ctr.sv
module cken_phase_ctr #(
   parameter int unsigned SLOW_DIV = 12,
   parameter int unsigned FAST_DIV = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_slow,
   output logic tick_fast
);
   localparam int unsigned PW     = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
   localparam int unsigned NFAST  = SLOW_DIV / FAST_DIV;
   localparam logic [PW-1:0] LAST = PW'(SLOW_DIV - 1);

   if (FAST_DIV == 0 || SLOW_DIV % FAST_DIV != 0 || FAST_DIV < 2) begin : g_bad_div
      $error("cken_phase_ctr: SLOW_DIV must be a multiple of FAST_DIV >= 2");
   end

   logic [PW-1:0] phase_q;
   logic [NFAST-1:0] hit;

   always_ff @(posedge clk) begin
      if (!rst_n)              phase_q <= '0;
      else if (phase_q == LAST) phase_q <= '0;
      else                     phase_q <= phase_q + 1'b1;
   end

   for (genvar k = 0; k < NFAST; k++) begin : g_fast_pt
      assign hit[k] = (phase_q == PW'(k * FAST_DIV));
   end

   assign tick_slow = (phase_q == '0);
   assign tick_fast = |hit;

   // R7
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= LAST);
endmodule

// File: rtl/cken_ctrl_reg.sv
module cken_ctrl_reg #(
   parameter int unsigned          ADDR_W   = 8,
   parameter int unsigned          DATA_W   = 8,
   parameter int unsigned          NUM_PER  = 6,
   parameter logic [ADDR_W-1:0]    REG_ADDR = 8'h8F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              x2_on,
   output logic [NUM_PER-1:0] per_std
);
   localparam int unsigned LIVE = NUM_PER + 1;

   if (DATA_W < LIVE) begin : g_bad_width
      $error("cken_ctrl_reg: DATA_W too small for NUM_PER select bits");
   end

   logic [DATA_W-1:0] reg_q;
   logic              hit;

   assign hit = (addr == REG_ADDR);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b < LIVE) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)        reg_q[b] <= 1'b0;
            else if (we && hit) reg_q[b] <= wdata[b];
         end
      end else begin : g_rsvd
         assign reg_q[b] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= hit ? reg_q : '0;
   end

   assign x2_on   = reg_q[0];
   assign per_std = reg_q[LIVE-1:1];

   // R4
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:LIVE] == '0);
   // R2
   foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !hit) |=> $stable(reg_q));
endmodule

// File: rtl/cken_lane.sv
module cken_lane #(
   parameter bit STB_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_slow,
   input  logic tick_fast,
   input  logic want_fast,
   output logic fast_now,
   output logic stb
);
   logic fast_q;
   logic stb_next;

   always_ff @(posedge clk) begin
      if (!rst_n)         fast_q <= 1'b0;
      else if (tick_slow) fast_q <= want_fast;
   end

   assign stb_next = tick_fast & (tick_slow | fast_q);
   assign fast_now = fast_q;

   if (STB_REG) begin : g_reg_out
      logic stb_q;
      always_ff @(posedge clk) begin
         if (!rst_n) stb_q <= 1'b0;
         else        stb_q <= stb_next;
      end
      assign stb = stb_q;
      // R7
      stb_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
         stb |-> $past(tick_fast));
   end else begin : g_comb_out
      assign stb = stb_next;
   end

   // R8
   switch_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fast_q) |-> $past(tick_slow));
endmodule

// File: rtl/dual_speed_cken.sv
module dual_speed_cken
   import cken_pkg::*;
#(
   parameter int unsigned       SLOW_DIV = DEF_SLOW_DIV,
   parameter int unsigned       FAST_DIV = DEF_FAST_DIV,
   parameter int unsigned       NUM_PER  = DEF_NUM_PER,
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       DATA_W   = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR = 8'h8F,
   parameter bit                STB_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic               core_stb,
   output logic [NUM_PER-1:0] per_stb
);
   localparam int unsigned NLANE = NUM_PER + 1;

   if (NUM_PER < 1) begin : g_bad_nper
      $error("dual_speed_cken: NUM_PER must be at least 1");
   end

   logic               tick_slow, tick_fast;
   logic               x2_on;
   logic [NUM_PER-1:0] per_std;
   logic [NLANE-1:0]   want_fast, fast_now, lane_stb;

   cken_phase_ctr #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) i_phase (
      .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast));

   cken_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PER(NUM_PER),
                   .REG_ADDR(REG_ADDR)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .x2_on(x2_on), .per_std(per_std));

   // lane 0 is the core, lane n+1 is peripheral n
   assign want_fast[0] = x2_on;
   for (genvar p = 0; p < NUM_PER; p++) begin : g_want
      assign want_fast[p+1] = x2_on & ~per_std[p];
   end

   for (genvar l = 0; l < NLANE; l++) begin : g_lane
      cken_lane #(.STB_REG(STB_REG)) i_lane (
         .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
         .want_fast(want_fast[l]), .fast_now(fast_now[l]), .stb(lane_stb[l]));
   end

   assign core_stb = lane_stb[0];
   assign per_stb  = lane_stb[NLANE-1:1];

   // R5
   per_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|fast_now[NLANE-1:1]) |-> fast_now[0]);
endmodule

// File: tb/test_dual_speed_cken.sv
module test_dual_speed_cken;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       core_stb;
   logic [5:0] per_stb;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   dual_speed_cken i_dual_speed_cken (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .core_stb(core_stb), .per_stb(per_stb));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
   endtask

   function automatic int exp_period(input logic [6:0] cfg, input int lane);
      if (lane == 0) return cfg[0] ? 6 : 12;
      return (cfg[0] && !cfg[lane]) ? 6 : 12;
   endfunction

   // measure intervals of all 7 lanes over a 48-clock window
   task automatic measure(input logic [6:0] cfg, input string req);
      int last[7];
      int cnt[7];
      int badv[7];
      int misalign;
      logic [6:0] s;
      for (int l = 0; l < 7; l++) begin last[l] = -1; cnt[l] = 0; badv[l] = -1; end
      misalign = 0;
      for (int c = 0; c < 48; c++) begin
         @(negedge clk);
         s = {per_stb, core_stb};
         for (int l = 0; l < 7; l++) begin
            if (s[l]) begin
               if (last[l] >= 0 && (c - last[l]) != exp_period(cfg, l)) badv[l] = c - last[l];
               if (exp_period(cfg, l) == 12 && !s[0]) misalign++;
               last[l] = c;
               cnt[l]++;
            end
         end
      end
      for (int l = 0; l < 7; l++) begin
         check(badv[l] < 0, req, badv[l], exp_period(cfg, l));
         check(cnt[l] == 48 / exp_period(cfg, l), req, cnt[l], 48 / exp_period(cfg, l));
      end
      check(misalign == 0, "R7 alignment", misalign, 0);
   endtask

   // write mid-frame just after a core strobe, then record the next three core intervals
   task automatic switch_run(input logic [7:0] newval, output int iv[3]);
      int t;
      int n;
      while (!core_stb) @(negedge clk);
      t = 0;
      @(negedge clk); t++;
      @(negedge clk); t++;
      reg_we = 1'b1; reg_addr = 8'h8F; reg_wdata = newval;
      @(negedge clk); t++;
      reg_we = 1'b0;
      n = 0;
      while (n < 3) begin
         if (core_stb) begin iv[n] = t; n++; t = 0; end
         @(negedge clk); t++;
      end
   endtask

   task automatic run_all();
      logic [7:0] d;
      int iv[3];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(8'h8F, d);
      check(d == 8'h00, "R1 reset value", d, 0);
      measure(7'h00, "R1 reset periods");

      // R3 read latency and foreign address
      wr(8'h8F, 8'h2A);
      rd(8'h8F, d);
      check(d == 8'h2A, "R3 read back", d, 8'h2A);
      rd(8'h8E, d);
      check(d == 8'h00, "R3 foreign read", d, 0);
      // R2 foreign write ignored
      wr(8'h8E, 8'h55);
      wr(8'h0F, 8'h01);
      rd(8'h8F, d);
      check(d == 8'h2A, "R2 foreign write", d, 8'h2A);
      // R4 reserved bit
      wr(8'h8F, 8'hFF);
      rd(8'h8F, d);
      check(d == 8'h7F, "R4 reserved bit", d, 8'h7F);
      wr(8'h8F, 8'h80);
      rd(8'h8F, d);
      check(d == 8'h00, "R4 reserved write", d, 0);

      // R5 / R6 exhaustive sweep over all live bit settings
      for (int cfg = 0; cfg < 128; cfg++) begin
         wr(8'h8F, 8'(cfg));
         rd(8'h8F, d);
         check(d == 8'(cfg), "R2 sweep readback", d, cfg);
         repeat (26) @(negedge clk);
         measure(7'(cfg), (cfg[0]) ? "R6 fast mode period" : "R5 standard mode period");
      end

      // R8 slow to fast mid-frame
      wr(8'h8F, 8'h00);
      repeat (30) @(negedge clk);
      switch_run(8'h01, iv);
      check(iv[0] == 12, "R8 slow->fast first", iv[0], 12);
      check(iv[1] == 6, "R8 slow->fast second", iv[1], 6);
      check(iv[2] == 6, "R8 slow->fast third", iv[2], 6);
      // R8 fast to slow mid-frame
      repeat (30) @(negedge clk);
      switch_run(8'h00, iv);
      check(iv[0] == 6, "R8 fast->slow first", iv[0], 6);
      check(iv[1] == 6 || iv[1] == 12, "R8 fast->slow second", iv[1], 12);
      check(iv[2] == 12, "R8 fast->slow third", iv[2], 12);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (200000) @(posedge clk);
            check(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule